// File: doc/BRIEF.md
# Segment Access Rights Checker

This block evaluates a 16-bit segment selector against the global or local descriptor table and returns the access-rights word of the selected descriptor together with a success flag. A request carries the selector, the current privilege level, a mode flag (legacy protected or 64-bit long mode), an operand-size code and the present value of the destination register. The block first rejects null selectors and selectors whose descriptor does not fit inside the table limit. When neither applies, it reads the upper doubleword of the 8-byte descriptor through a simple request/acknowledge memory port. It then applies a per-mode type filter and a privilege test, and merges the packed rights into the destination value.

Requests enter on a valid/ready pair. `in_ready` is high only while the block is idle, and the block captures a request on any clock edge where `in_valid` and `in_ready` are both high. A request presented while the block is busy waits: it is neither lost nor merged into the operation in flight. The memory port applies back-pressure through `mem_ack`. Once raised, `mem_req` and `mem_addr` stay unchanged until the edge on which `mem_ack` is high, and `mem_rdata` is sampled on that edge. The result has no back-pressure. `done` is high for one cycle, and `ok` and `dest_out` are valid in that cycle.

Top module: `seg_rights_checker`

## Requirements
- R1: `in_ready` is 1 exactly when no operation is in progress. After reset it is 1. It is 0 from the cycle after a request is captured until `done` rises. A request presented while `in_ready` is 0 is not captured and does not alter the operation in flight.
- R2: `done` is high for exactly one cycle per captured request. For a request rejected without a fetch, it rises in the second cycle after capture. For a fetched request, it rises in the cycle after the `mem_ack` edge. `done` may coincide with `in_ready` and with the capture of a new request.
- R3: The selector splits into three fields: index in bits 15:3, table select in bit 2 (0 = global, 1 = local), and requested privilege level (RPL) in bits 1:0. Index 0 with table select 0 is null. A null selector fails with no memory request.
- R4: The operation fails with no memory request when index*8+7 exceeds the limit of the selected table. Local index 0 is not null and is subject only to this test.
- R5: The memory read address is table base + index*8 + 4. `mem_req` and `mem_addr` hold steady until `mem_ack`, and any number of wait cycles is allowed.
- R6: In the fetched doubleword, type is bits 11:8, S bit 12, DPL bits 14:13, P bit 15, software-available bit 20, L bit 21, D/B bit 22 and G bit 23. Any descriptor with S=1 passes the type filter.
- R7: In legacy mode (`in_long_mode`=0), a descriptor with S=0 passes the type filter only for types 1, 2, 3, 4, 5, 9, 11 and 12.
- R8: In long mode (`in_long_mode`=1), a descriptor with S=0 passes the type filter only for types 2, 9, 11 and 12.
- R9: A conforming code descriptor (S=1, type bits 3 and 2 both 1) skips the privilege test. Any other descriptor fails when CPL > DPL or RPL > DPL.
- R10: For operand-size code 0 (16 bits), success returns `dest_out` = {`in_dest`[63:16], P, DPL, S, type, 8'h00}.
- R11: For operand-size codes 1, 2 and 3, success returns `dest_out` = zero-extended {8'h00, G, D/B, L, available, 4'h0, P, DPL, S, type, 8'h00}.
- R12: On success `ok`=1. On any failed check, `ok`=0 and `dest_out` equals the `in_dest` of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle, request can be captured |
| in_selector | input | 16 | Segment selector |
| in_cpl | input | 2 | Current privilege level |
| in_long_mode | input | 1 | 1 = long mode type filter |
| in_op_size | input | 2 | 0 = 16-bit, 1 = 32-bit, 2 = 64-bit |
| in_dest | input | 64 | Present destination value |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | LIM_W | Global table limit in bytes |
| ldt_base | input | ADDR_W | Local table base address |
| ldt_limit | input | LIM_W | Local table limit in bytes |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | ADDR_W | Byte address of the upper doubleword |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Upper descriptor doubleword |
| done | output | 1 | One-cycle result strobe |
| ok | output | 1 | Success flag |
| dest_out | output | 64 | Merged destination value |

## Verification
The result strobe of one operation and the capture of the next request can fall in the same cycle, because `in_ready` returns to 1 in the very cycle that `done` is high. The bench provokes this by issuing a null selector and then holding a second, valid request on `in_valid` throughout the busy window. It checks that the second request was refused while busy and that the first result appears intact alongside `in_ready`=1. It then checks that the second request completes with its own address and rights, not those of the first.

// File: rtl/seg_rights_pkg.sv
package seg_rights_pkg;

  typedef enum logic [1:0] {
    SZ16   = 2'd0,
    SZ32   = 2'd1,
    SZ64   = 2'd2,
    SZ_RSV = 2'd3
  } opsz_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_FETCH = 2'd2
  } seq_e;

  typedef struct packed {
    logic [12:0] index;
    logic        ti;
    logic [1:0]  rpl;
  } sel_t;

  typedef struct packed {
    logic [7:0] base_top;
    logic       g;
    logic       db;
    logic       l;
    logic       avl;
    logic [3:0] lim_top;
    logic       p;
    logic [1:0] dpl;
    logic       s;
    logic [3:0] typ;
    logic [7:0] base_mid;
  } desc_hi_t;

  // bit n set: system type n passes the filter
  localparam logic [15:0] SYS_OK_LEGACY = 16'h1A3E;
  localparam logic [15:0] SYS_OK_LONG   = 16'h1A04;

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_rights_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 32
) (
  input  sel_t              sel,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [LIM_W-1:0]  gdt_limit,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic [LIM_W-1:0]  ldt_limit,
  output logic              is_null,
  output logic              over_limit,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam int CW = (LIM_W > 16) ? LIM_W : 16;

  logic [15:0]       last_byte;
  logic [15:0]       hi_off;
  logic [LIM_W-1:0]  lim;
  logic [ADDR_W-1:0] base;

  assign last_byte  = {sel.index, 3'b111};
  assign hi_off     = {sel.index, 3'b100};
  assign lim        = sel.ti ? ldt_limit : gdt_limit;
  assign base       = sel.ti ? ldt_base  : gdt_base;
  assign is_null    = (sel.index == '0) && !sel.ti;
  assign over_limit = CW'(last_byte) > CW'(lim);
  assign fetch_addr = base + ADDR_W'(hi_off);
endmodule

// File: rtl/seg_type_filter.sv
module seg_type_filter
  import seg_rights_pkg::*;
(
  input  logic       long_mode,
  input  logic       s,
  input  logic [3:0] typ,
  input  logic [1:0] dpl,
  input  logic [1:0] cpl,
  input  logic [1:0] rpl,
  output logic       accept
);
  logic [15:0] sys_mask;
  logic        type_ok;
  logic        conforming;
  logic        priv_ok;

  assign sys_mask   = long_mode ? SYS_OK_LONG : SYS_OK_LEGACY;
  assign type_ok    = s | sys_mask[typ];
  assign conforming = s & typ[3] & typ[2];
  assign priv_ok    = conforming | ((cpl <= dpl) & (rpl <= dpl));
  assign accept     = type_ok & priv_ok;
endmodule

// File: rtl/seg_rights_pack.sv
module seg_rights_pack
  import seg_rights_pkg::*;
#(
  parameter int DEST_W = 64
) (
  input  opsz_e             op,
  input  desc_hi_t          d,
  input  logic [DEST_W-1:0] dst,
  output logic [DEST_W-1:0] merged
);
  logic [31:0] rights;
  logic        unused_desc;

  assign rights = {8'h00, d.g, d.db, d.l, d.avl, 4'h0, d.p, d.dpl, d.s, d.typ, 8'h00};
  assign unused_desc = ^{d.base_top, d.lim_top, d.base_mid};

  generate
    if (DEST_W > 32) begin : g_wide
      assign merged = (op == SZ16) ? {dst[DEST_W-1:16], rights[15:0]}
                                   : {{(DEST_W-32){1'b0}}, rights};
    end else begin : g_narrow
      assign merged = (op == SZ16) ? {dst[DEST_W-1:16], rights[15:0]}
                                   : rights[DEST_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/seg_rights_checker.sv
module seg_rights_checker
  import seg_rights_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 32,
  parameter int DEST_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_selector,
  input  logic [1:0]        in_cpl,
  input  logic              in_long_mode,
  input  logic [1:0]        in_op_size,
  input  logic [DEST_W-1:0] in_dest,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [LIM_W-1:0]  gdt_limit,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic [LIM_W-1:0]  ldt_limit,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic              ok,
  output logic [DEST_W-1:0] dest_out
);
  seq_e              state;
  sel_t              sel_q;
  logic [1:0]        cpl_q;
  logic              lm_q;
  opsz_e             op_q;
  logic [DEST_W-1:0] dst_q;

  logic              sel_null;
  logic              sel_over;
  logic [ADDR_W-1:0] fetch_addr;
  desc_hi_t          desc;
  logic              accept;
  logic [DEST_W-1:0] dest_new;

  assign desc = desc_hi_t'(mem_rdata);

  seg_sel_decode #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_decode (
    .sel        (sel_q),
    .gdt_base   (gdt_base),
    .gdt_limit  (gdt_limit),
    .ldt_base   (ldt_base),
    .ldt_limit  (ldt_limit),
    .is_null    (sel_null),
    .over_limit (sel_over),
    .fetch_addr (fetch_addr)
  );

  seg_type_filter u_filter (
    .long_mode (lm_q),
    .s         (desc.s),
    .typ       (desc.typ),
    .dpl       (desc.dpl),
    .cpl       (cpl_q),
    .rpl       (sel_q.rpl),
    .accept    (accept)
  );

  seg_rights_pack #(.DEST_W(DEST_W)) u_pack (
    .op     (op_q),
    .d      (desc),
    .dst    (dst_q),
    .merged (dest_new)
  );

  assign in_ready = (state == ST_IDLE);
  assign mem_req  = (state == ST_FETCH);
  assign mem_addr = fetch_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sel_q    <= '0;
      cpl_q    <= '0;
      lm_q     <= 1'b0;
      op_q     <= SZ16;
      dst_q    <= '0;
      done     <= 1'b0;
      ok       <= 1'b0;
      dest_out <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            sel_q <= sel_t'(in_selector);
            cpl_q <= in_cpl;
            lm_q  <= in_long_mode;
            op_q  <= opsz_e'(in_op_size);
            dst_q <= in_dest;
            state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (sel_null || sel_over) begin
            done     <= 1'b1;
            ok       <= 1'b0;
            dest_out <= dst_q;
            state    <= ST_IDLE;
          end else begin
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            done     <= 1'b1;
            ok       <= accept;
            dest_out <= accept ? dest_new : dst_q;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_rights_sva.sv
module seg_rights_sva #(
  parameter int ADDR_W = 32,
  parameter int DEST_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [15:0]       in_selector,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              ok,
  input logic [DEST_W-1:0] dest_out,
  input logic [DEST_W-1:0] dst_q,
  input logic [1:0]        op_q
);
  p_busy_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_null_no_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_selector[15:2] == 14'd0) |=> !mem_req ##1 (done && !ok));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_keep16_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok && op_q == 2'd0) |->
      (dest_out[DEST_W-1:16] == dst_q[DEST_W-1:16] && dest_out[7:0] == 8'h00));

  p_zero_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok && op_q != 2'd0) |->
      (dest_out[DEST_W-1:24] == '0 && dest_out[19:16] == 4'h0 && dest_out[7:0] == 8'h00));

  p_fail_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> (dest_out == dst_q));
endmodule

bind seg_rights_checker seg_rights_sva #(.ADDR_W(ADDR_W), .DEST_W(DEST_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_selector (in_selector),
  .mem_req     (mem_req),
  .mem_ack     (mem_ack),
  .mem_addr    (mem_addr),
  .done        (done),
  .ok          (ok),
  .dest_out    (dest_out),
  .dst_q       (dst_q),
  .op_q        (op_q)
);

// File: tb/test_seg_rights_checker.sv
`timescale 1ns/1ps
module test_seg_rights_checker;
  localparam logic [31:0] GB = 32'h0001_0000;
  localparam logic [31:0] GL = 32'h0000_00FF;
  localparam logic [31:0] LB = 32'h0002_0000;
  localparam logic [31:0] LL = 32'h0000_003F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_selector = '0;
  logic [1:0]  in_cpl = '0;
  logic        in_long_mode = 1'b0;
  logic [1:0]  in_op_size = '0;
  logic [63:0] in_dest = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic        ok;
  logic [63:0] dest_out;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  seg_rights_checker i_seg_rights_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_selector(in_selector), .in_cpl(in_cpl), .in_long_mode(in_long_mode),
    .in_op_size(in_op_size), .in_dest(in_dest),
    .gdt_base(GB), .gdt_limit(GL), .ldt_base(LB), .ldt_limit(LL),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .ok(ok), .dest_out(dest_out)
  );

  task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] sel, input logic [1:0] cpl, input logic lm,
                                input logic [1:0] op, input logic [63:0] dst, input logic [31:0] desc,
                                output bit e_fetch, output logic [31:0] e_addr,
                                output bit e_ok, output logic [63:0] e_dest);
    int idx = int'(sel[15:3]);
    int lim = sel[2] ? int'(LL) : int'(GL);
    logic [31:0] base = sel[2] ? LB : GB;
    logic [3:0] t = desc[11:8];
    logic s = desc[12];
    logic [1:0] dpl = desc[14:13];
    logic [1:0] rpl = sel[1:0];
    bit tok, pok, conf;
    e_fetch = 1'b0; e_ok = 1'b0; e_dest = dst; e_addr = '0;
    if (idx == 0 && !sel[2]) return;
    if (idx * 8 + 7 > lim) return;
    e_fetch = 1'b1;
    e_addr = base + 32'(idx * 8 + 4);
    if (s) tok = 1'b1;
    else if (lm) tok = (t == 2 || t == 9 || t == 11 || t == 12);
    else tok = (t == 1 || t == 2 || t == 3 || t == 4 || t == 5 || t == 9 || t == 11 || t == 12);
    conf = s && t[3] && t[2];
    pok = conf || (cpl <= dpl && rpl <= dpl);
    e_ok = tok && pok;
    if (e_ok) begin
      if (op == 2'd0) e_dest = {dst[63:16], desc[15:8], 8'h00};
      else e_dest = {32'h0, 8'h00, desc[23:20], 4'h0, desc[15:8], 8'h00};
    end
  endfunction

  // starts at the negedge where the request sits in the check cycle
  task automatic complete(input logic [15:0] sel, input logic [1:0] cpl, input logic lm,
                          input logic [1:0] op, input logic [63:0] dst, input logic [31:0] desc,
                          input int lat);
    bit e_fetch, e_ok, fetched = 1'b0, got = 1'b0;
    logic [31:0] e_addr;
    logic [63:0] e_dest;
    int cyc = 0, waited = 0, ack_cyc = -1;
    model(sel, cpl, lm, op, dst, desc, e_fetch, e_addr, e_ok, e_dest);
    while (!got && cyc < 40) begin
      if (mem_req) begin
        if (!fetched) chk(mem_addr == e_addr, "R5 fetch address", 64'(mem_addr), 64'(e_addr));
        fetched = 1'b1;
        if (waited >= lat) begin mem_ack = 1'b1; mem_rdata = desc; ack_cyc = cyc; end
        else begin mem_ack = 1'b0; mem_rdata = 32'hDEAD_BEEF; waited++;
          chk(!in_ready, "R1 ready low while waiting", 64'(in_ready), 64'd0); end
      end else mem_ack = 1'b0;
      if (done) got = 1'b1;
      else begin @(negedge clk); cyc++; end
    end
    mem_ack = 1'b0;
    chk(got, "R2 done seen", 64'(got), 64'd1);
    chk(fetched == e_fetch, "R3/R4 fetch issued", 64'(fetched), 64'(e_fetch));
    if (e_fetch) chk(cyc == ack_cyc + 1, "R2 done after ack", 64'(cyc), 64'(ack_cyc + 1));
    else chk(cyc == 1, "R2 reject timing", 64'(cyc), 64'd1);
    chk(ok == e_ok, "R6/R7/R8/R9 ok flag", 64'(ok), 64'(e_ok));
    chk(dest_out == e_dest, e_ok ? (op == 2'd0 ? "R10 dest" : "R11 dest") : "R12 dest",
        dest_out, e_dest);
  endtask

  task automatic run_op(input logic [15:0] sel, input logic [1:0] cpl, input logic lm,
                        input logic [1:0] op, input logic [63:0] dst, input logic [31:0] desc,
                        input int lat);
    @(negedge clk);
    in_selector = sel; in_cpl = cpl; in_long_mode = lm; in_op_size = op; in_dest = dst;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_selector = 16'hFFFF; in_dest = ~dst;
    complete(sel, cpl, lm, op, dst, desc, lat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", 64'(in_ready), 64'd1);
    chk(done == 1'b0 && mem_req == 1'b0, "R2 idle after reset", 64'({done, mem_req}), 64'd0);

    // R6 R7 R8 R9 sweep: mode x S x type x DPL x CPL x RPL
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] d;
      logic [15:0] sel;
      logic ti = (i % 5 == 0);
      int idx = ti ? 1 + (i % 7) : 1 + (i % 31);
      d = {8'hA5, 4'(i >> 1), 4'hC, 1'b1, 2'(i >> 4), 1'(i >> 10), 4'(i >> 6), 8'h5A};
      sel = {13'(idx), ti, 2'(i)};
      run_op(sel, 2'(i >> 2), 1'(i >> 11), 2'(i % 3), {32'(i * 7919), 32'(~i)}, d, i % 3);
    end

    // R3 R4 boundary sweep over both tables
    for (int ti = 0; ti < 2; ti++)
      for (int idx = 0; idx < 40; idx++)
        run_op({13'(idx), 1'(ti), 2'(idx)}, 2'd3, 1'(idx), 2'(idx % 3),
               64'h0123_4567_89AB_CDEF, 32'hFFF3_EA77, idx % 2);

    // R1 R2: second request held during the first, captured with the done pulse
    @(negedge clk);
    in_selector = 16'h0003; in_cpl = 2'd0; in_long_mode = 1'b0; in_op_size = 2'd1;
    in_dest = 64'hAAAA_BBBB_CCCC_DDDD; in_valid = 1'b1;
    @(negedge clk);
    in_selector = 16'h0048; in_cpl = 2'd0; in_op_size = 2'd0; in_dest = 64'h1111_2222_3333_4444;
    chk(in_ready == 1'b0, "R1 busy refuses second request", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk(done && !ok, "R3 null result beside new capture", 64'({done, ok}), 64'h2);
    chk(dest_out == 64'hAAAA_BBBB_CCCC_DDDD, "R12 first result intact", dest_out, 64'hAAAA_BBBB_CCCC_DDDD);
    chk(in_ready == 1'b1, "R2 done with ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R1 second request captured", 64'(in_ready), 64'd0);
    complete(16'h0048, 2'd0, 1'b0, 2'd0, 64'h1111_2222_3333_4444, 32'h00F0_9A00, 2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule